// File: doc/BRIEF.md
# Bridge Error Status Aggregator

This block sits beside a bus bridge and gathers the error events that the bridge's two sides and the system bus report. Each cycle it looks at single-cycle error pulses, qualifies each class of error with the enable bit that software has set in the command register, and raises a one-cycle system-error strobe on the next clock. It also drives an active-low pin level that follows the strobe.

Events are logged in sticky bits that software clears by writing 1. A 16-bit status word carries the detected-parity and signaled-system-error bits, plus a hard-wired capabilities bit. A separate 3-bit register holds the system-bus error flags. Both registers share one write port with byte enables. When a hardware set and a software clear hit the same bit in the same clock, the set wins, so no event is lost.

Top module: `brg_err_agg`

## Requirements
- R1: After reset, `status_q` reads 16'h0010, `sysbus_sts` reads 0, `serr_strobe` is 0 and `serr_n` is 1.
- R2: Bit 15 of `status_q` becomes 1 on the clock after `pri_data_perr` is high, whatever the value of `pri_perr_en`. A `pri_master_err` pulse on its own never sets bit 15.
- R3: A `pri_data_perr` or `pri_master_err` pulse raises `serr_strobe` on the next clock only when `pri_perr_en` is 1.
- R4: A `sec_data_perr` or `sec_master_err` pulse raises `serr_strobe` on the next clock only when `sec_perr_en` is 1.
- R5: A pulse on `sysbus_err[i]` sets the sticky bit `sysbus_sts[i]` on the next clock whatever the enables are. It raises `serr_strobe` only when `sysbus_en[i]` is 1.
- R6: `serr_strobe` is high for exactly the clock after each cycle in which some enabled class fires, and low otherwise. `serr_n` is always its inverse.
- R7: Bit 14 of `status_q` becomes 1 with the strobe only when `serr_en` is 1.
- R8: A write with `reg_addr` = 8'h06 and `reg_be[1]` = 1 clears bit 15 and/or bit 14 where the matching `reg_wdata` bit is 1. A data bit of 0, `reg_be[1]` = 0, or any other address leaves them unchanged. Bit 4 always reads 1, and every other bit always reads 0.
- R9: A write with `reg_addr` = 8'h40 and `reg_be[0]` = 1 clears each `sysbus_sts[i]` whose `reg_wdata[i]` is 1. When `reg_be[0]` = 0 the write has no effect.
- R10: When a bit is set by hardware and cleared by a write in the same clock, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_data_perr | input | 1 | Data parity error seen on the primary path |
| pri_master_err | input | 1 | Error returned on a primary cycle the bridge mastered |
| sec_data_perr | input | 1 | Data parity error seen on the secondary bus |
| sec_master_err | input | 1 | Error returned on a secondary cycle the bridge mastered |
| sysbus_err | input | 3 | System-bus error pulses, one per source |
| pri_perr_en | input | 1 | Primary parity-error response enable (command bit 6) |
| sec_perr_en | input | 1 | Secondary parity-error response enable |
| sysbus_en | input | 3 | Per-source system-bus error enables |
| serr_en | input | 1 | System-error enable (command bit 8) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the write |
| reg_wdata | input | 16 | Write data |
| reg_be | input | 2 | Byte enables: [0] low byte, [1] high byte |
| status_q | output | 16 | Status word |
| sysbus_sts | output | 3 | Sticky system-bus error flags |
| serr_strobe | output | 1 | One-cycle system-error strobe |
| serr_n | output | 1 | Active-low system-error pin level |

## Verification
The assertions check on every cycle that the strobe follows an enabled event by exactly one clock and never appears without one. They also check that bit 15 and the system-bus flags latch their events, that bit 14 rises only under `serr_en`, that a same-cycle set beats a clear, and that a low-byte-only write keeps the high bits. The directed scenarios are needed to show that a gated event leaves the outputs unchanged, that partial and misaddressed writes are ignored, and that each enable masks its own class without touching the others.

// File: rtl/brg_err_agg.sv
module brg_err_agg #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SYS_W    = 3,
  parameter logic [7:0]  STS_ADDR = 8'h06,
  parameter logic [7:0]  SYS_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_data_perr,
  input  logic              pri_master_err,
  input  logic              sec_data_perr,
  input  logic              sec_master_err,
  input  logic [SYS_W-1:0]  sysbus_err,
  input  logic              pri_perr_en,
  input  logic              sec_perr_en,
  input  logic [SYS_W-1:0]  sysbus_en,
  input  logic              serr_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  input  logic [1:0]        reg_be,
  output logic [15:0]       status_q,
  output logic [SYS_W-1:0]  sysbus_sts,
  output logic              serr_strobe,
  output logic              serr_n
);

  logic pri_fire, sec_fire, sys_fire, any_fire;
  logic wr_sts_hi, wr_sys_lo;
  logic dpe_q, sse_q, strobe_q;
  logic [SYS_W-1:0] sys_q, sys_clr;
  logic unused_wdata;

  assign pri_fire = pri_perr_en & (pri_data_perr | pri_master_err);
  assign sec_fire = sec_perr_en & (sec_data_perr | sec_master_err);
  assign sys_fire = |(sysbus_err & sysbus_en);
  assign any_fire = pri_fire | sec_fire | sys_fire;

  assign wr_sts_hi = reg_wr & (reg_addr == ADDR_W'(STS_ADDR)) & reg_be[1];
  assign wr_sys_lo = reg_wr & (reg_addr == ADDR_W'(SYS_ADDR)) & reg_be[0];
  assign sys_clr   = wr_sys_lo ? reg_wdata[SYS_W-1:0] : '0;
  assign unused_wdata = ^reg_wdata[13:SYS_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dpe_q    <= 1'b0;
      sse_q    <= 1'b0;
      sys_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      dpe_q    <= (dpe_q & ~(wr_sts_hi & reg_wdata[15])) | pri_data_perr;
      sse_q    <= (sse_q & ~(wr_sts_hi & reg_wdata[14])) | (any_fire & serr_en);
      sys_q    <= (sys_q & ~sys_clr) | sysbus_err;
      strobe_q <= any_fire;
    end
  end

  assign status_q    = {dpe_q, sse_q, 9'b0, 1'b1, 4'b0};
  assign sysbus_sts  = sys_q;
  assign serr_strobe = strobe_q;
  assign serr_n      = ~strobe_q;

endmodule

// File: rtl/brg_err_agg_chk.sv
module brg_err_agg_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SYS_W    = 3,
  parameter logic [7:0]  STS_ADDR = 8'h06,
  parameter logic [7:0]  SYS_ADDR = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pri_data_perr,
  input logic              pri_master_err,
  input logic              sec_data_perr,
  input logic              sec_master_err,
  input logic [SYS_W-1:0]  sysbus_err,
  input logic              pri_perr_en,
  input logic              sec_perr_en,
  input logic [SYS_W-1:0]  sysbus_en,
  input logic              serr_en,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       reg_wdata,
  input logic [1:0]        reg_be,
  input logic [15:0]       status_q,
  input logic [SYS_W-1:0]  sysbus_sts,
  input logic              serr_strobe,
  input logic              serr_n
);

  logic ev, clr15, lo_only, unused_chk;
  assign ev = (pri_perr_en & (pri_data_perr | pri_master_err)) |
              (sec_perr_en & (sec_data_perr | sec_master_err)) |
              (|(sysbus_err & sysbus_en));
  assign clr15 = reg_wr && reg_addr == ADDR_W'(STS_ADDR) && reg_be[1] && reg_wdata[15];
  assign lo_only = !(reg_wr && reg_addr == ADDR_W'(STS_ADDR) && reg_be[1]);
  assign unused_chk = ^{reg_wdata[13:0], status_q[13:0], SYS_ADDR};

  a_r6_strobe_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> serr_strobe);
  a_r6_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !ev |=> !serr_strobe);
  a_r6_pin_level: assert property (@(posedge clk) disable iff (!rst_n)
    serr_strobe |-> !serr_n);
  a_r2_dpe_latches: assert property (@(posedge clk) disable iff (!rst_n)
    pri_data_perr |=> status_q[15]);
  a_r7_sse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[14] && !(ev && serr_en)) |=> !status_q[14]);
  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_data_perr && clr15) |=> status_q[15]);
  a_r8_low_byte_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[15] && lo_only) |=> status_q[15]);
  a_r5_sysbus_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|sysbus_err) |=> ((sysbus_sts & $past(sysbus_err)) == $past(sysbus_err)));

endmodule

bind brg_err_agg brg_err_agg_chk #(
  .ADDR_W(ADDR_W), .SYS_W(SYS_W), .STS_ADDR(STS_ADDR), .SYS_ADDR(SYS_ADDR)
) chk_i (.*);

// File: tb/brg_err_agg_tb_top.sv
`timescale 1ns/1ps
module brg_err_agg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pri_data_perr = 0, pri_master_err = 0, sec_data_perr = 0, sec_master_err = 0;
  logic [2:0] sysbus_err = '0, sysbus_en = '0;
  logic pri_perr_en = 0, sec_perr_en = 0, serr_en = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [1:0] reg_be = '0;
  logic [15:0] status_q;
  logic [2:0] sysbus_sts;
  logic serr_strobe, serr_n;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  brg_err_agg dut_i (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_ev();
    pri_data_perr = 0; pri_master_err = 0; sec_data_perr = 0; sec_master_err = 0;
    sysbus_err = '0; reg_wr = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    tick();
    reg_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", status_q, 16'h0010);
    chk("R1 sysbus", {13'b0, sysbus_sts}, 16'h0);
    chk("R1 strobe", {15'b0, serr_strobe}, 16'h0);
    chk("R1 pin", {15'b0, serr_n}, 16'h1);
  endtask

  task automatic t_detect();
    pri_perr_en = 0; serr_en = 1;
    pri_data_perr = 1; tick(); clear_ev();
    chk("R2 dpe without enable", status_q, 16'h8010);
    chk("R3 gated strobe", {15'b0, serr_strobe}, 16'h0);
    wr(8'h06, 16'h8000, 2'b10);
    chk("R8 clear dpe", status_q, 16'h0010);
    pri_master_err = 1; tick(); clear_ev();
    chk("R2 master err no dpe", status_q, 16'h0010);
  endtask

  task automatic t_primary();
    pri_perr_en = 1; serr_en = 0;
    pri_master_err = 1; tick(); clear_ev();
    chk("R3 strobe", {15'b0, serr_strobe}, 16'h1);
    chk("R6 pin low", {15'b0, serr_n}, 16'h0);
    chk("R7 no sse without enable", status_q, 16'h0010);
    tick();
    chk("R6 strobe one cycle", {15'b0, serr_strobe}, 16'h0);
    serr_en = 1; pri_data_perr = 1; tick(); clear_ev();
    chk("R7 sse and dpe", status_q, 16'hC010);
    chk("R3 strobe data perr", {15'b0, serr_strobe}, 16'h1);
    pri_perr_en = 0;
  endtask

  task automatic t_writes();
    wr(8'h06, 16'hFFFF, 2'b01);
    chk("R8 low byte only", status_q, 16'hC010);
    wr(8'h06, 16'h0000, 2'b11);
    chk("R8 zero data", status_q, 16'hC010);
    wr(8'h08, 16'hFFFF, 2'b11);
    chk("R8 other address", status_q, 16'hC010);
    wr(8'h06, 16'h4000, 2'b10);
    chk("R8 clear sse only", status_q, 16'h8010);
    wr(8'h06, 16'h8000, 2'b10);
    chk("R8 clear dpe", status_q, 16'h0010);
  endtask

  task automatic t_secondary();
    serr_en = 1; sec_perr_en = 0;
    sec_data_perr = 1; tick(); clear_ev();
    chk("R4 gated", {15'b0, serr_strobe}, 16'h0);
    chk("R4 gated status", status_q, 16'h0010);
    sec_perr_en = 1; sec_master_err = 1; tick(); clear_ev();
    chk("R4 strobe", {15'b0, serr_strobe}, 16'h1);
    chk("R4 sse", status_q, 16'h4010);
    sec_perr_en = 0;
    wr(8'h06, 16'h4000, 2'b10);
  endtask

  task automatic t_sysbus();
    serr_en = 0; sysbus_en = 3'b010;
    sysbus_err = 3'b101; tick(); clear_ev();
    chk("R5 sticky without enable", {13'b0, sysbus_sts}, 16'h5);
    chk("R5 masked strobe", {15'b0, serr_strobe}, 16'h0);
    sysbus_err = 3'b010; tick(); clear_ev();
    chk("R5 sticky or", {13'b0, sysbus_sts}, 16'h7);
    chk("R5 enabled strobe", {15'b0, serr_strobe}, 16'h1);
    wr(8'h40, 16'h0005, 2'b01);
    chk("R9 clear two", {13'b0, sysbus_sts}, 16'h2);
    wr(8'h40, 16'h0007, 2'b10);
    chk("R9 no byte enable", {13'b0, sysbus_sts}, 16'h2);
    wr(8'h40, 16'h0002, 2'b01);
    chk("R9 clear last", {13'b0, sysbus_sts}, 16'h0);
    sysbus_en = '0;
  endtask

  task automatic t_race();
    pri_data_perr = 1; tick(); clear_ev();
    pri_data_perr = 1;
    reg_wr = 1; reg_addr = 8'h06; reg_wdata = 16'h8000; reg_be = 2'b10;
    sysbus_err = 3'b001; tick(); clear_ev();
    chk("R10 dpe set wins", status_q, 16'h8010);
    sysbus_err = 3'b001; tick(); clear_ev();
    reg_wr = 1; reg_addr = 8'h40; reg_wdata = 16'h0001; reg_be = 2'b01;
    sysbus_err = 3'b001; tick(); clear_ev();
    chk("R10 sysbus set wins", {13'b0, sysbus_sts}, 16'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1;
    tick();
    t_detect();
    t_primary();
    t_writes();
    t_secondary();
    t_sysbus();
    t_race();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule